// File: doc/BRIEF.md
# PCI Configuration Address/Data Bridge

This block gives a host processor indirect access to PCI configuration space through two small register windows. The first window holds a 32-bit address register. Its top bit enables configuration cycles, and its lower fields select a bus, a device, a function and a register. The second window is a 4-byte data port. Each read or write on the data port turns into one configuration access on the downstream side, aimed at the target that the address register selects. The low two bits of the data-port offset are folded into the register number.

Before an access reaches the downstream port, the block applies a set of gates. The enable bit must be set. The access size must be legal. The target must answer, be powered, and not be an orphaned hot-added function, meaning one whose function 0 is missing. The register offset must lie below the window limit, which is clamped to 256 bytes unless the bus reports that extended space is allowed. The forwarded length is cut so the access does not cross the limit. A read that fails any gate returns all ones. A write that fails any gate is dropped. Responses come back one cycle after the request, together with the read data.

Top module: `cfg_bridge`

## Requirements
- R1: After reset the address register reads as 0x00000000, so configuration access is disabled and a data-window read returns 0xFFFFFFFF.
- R2: An address-window write (req_win=0) updates the address register only when req_off is 0 and req_size is 4. Any other address-window write leaves the register unchanged.
- R3: An address-window read returns the full 32-bit address register for every offset and size.
- R4: When bit 31 of the address register is 0, a data-window access (req_win=1) raises no downstream strobe, and a read returns 0xFFFFFFFF.
- R5: The effective address is the address register ORed with req_off. The downstream fields are decoded from it as follows: dn_bus is bits 23:16, dn_dev is bits 15:11, dn_fn is bits 10:8, and dn_reg is bits 7:0.
- R6: If dn_present is 0 for the decoded target, a read returns 0xFFFFFFFF and a write raises no strobe.
- R7: The window limit is win_limit, except that a limit above 256 is reduced to 256 when dn_ext_ok is 0. A register offset at or above the limit raises no strobe, and a read of it returns 0xFFFFFFFF.
- R8: dn_len is the smaller of req_size and (limit − dn_reg).
- R9: A target with dn_powered=0, or with dn_hotplug=1 while dn_fn0=0, is treated as absent: no strobe, and a read returns 0xFFFFFFFF.
- R10: A data-window access whose req_size is not 1, 2 or 4 raises no strobe, and a read of that kind returns 0xFFFFFFFF.
- R11: dn_valid is asserted in the same cycle as the request. rsp_valid follows every request exactly one cycle later. A forwarded read returns the dn_rdata value sampled in the request cycle.
- R12: On a forwarded write, dn_write is 1 and dn_wdata equals req_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_win | input | 1 | 0 = address window, 1 = data window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 2 | Byte offset inside the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| win_limit | input | 13 | Requested configuration-space limit in bytes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data returned with the response |
| dn_valid | output | 1 | Downstream configuration access strobe |
| dn_write | output | 1 | Downstream access is a write |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_reg | output | 8 | Register offset in configuration space |
| dn_len | output | 3 | Forwarded byte length |
| dn_wdata | output | 32 | Downstream write data |
| dn_present | input | 1 | A target answers at the decoded address |
| dn_powered | input | 1 | Target is powered |
| dn_fn0 | input | 1 | Function 0 of the target's device is present |
| dn_hotplug | input | 1 | Target was hot-added |
| dn_ext_ok | input | 1 | Bus allows extended configuration space |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The address register is the only stored state. A corrupted value appears in two places: on the very next address-window read, and on the decoded bus, device, function and register fields of the next data-window access, in that access's own request cycle. A gate that is wrongly open or closed appears in the same cycle as a dn_valid that should not be there or that is missing. One cycle later it appears as read data that is all ones when it should not be, or not all ones when it should be. A length error appears on dn_len in the request cycle, with no delay.

// File: rtl/cfg_bridge_pkg.sv
`timescale 1ns/1ps
package cfg_bridge_pkg;

  typedef enum logic {
    WIN_ADDR = 1'b0,
    WIN_DATA = 1'b1
  } win_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [7:0] roff;
  } cfg_tgt_t;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
`timescale 1ns/1ps
module cfg_addr_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] addr_q
);

  logic [DW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) addr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

endmodule

// File: rtl/cfg_gate.sv
`timescale 1ns/1ps
module cfg_gate
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LIM_W = 13,
  parameter int unsigned SPACE = 256
) (
  input  logic [DW-1:0]    addr_q,
  input  logic [1:0]       off,
  input  logic [2:0]       size,
  input  logic [LIM_W-1:0] limit_req,
  input  logic             present,
  input  logic             powered,
  input  logic             fn0,
  input  logic             hotplug,
  input  logic             ext_ok,
  output cfg_tgt_t         tgt,
  output logic [2:0]       len,
  output logic             pass
);

  localparam int unsigned OFFW = $clog2(SPACE);
  localparam logic [LIM_W-1:0] SPACE_L = LIM_W'(SPACE);

  logic [DW-1:0]    eff;
  logic [LIM_W-1:0] lim_eff;
  logic [LIM_W-1:0] roff_l;
  logic [LIM_W-1:0] room;
  logic             in_range;
  logic             live;
  logic [6:0]       unused_hi;

  assign eff       = addr_q | {{(DW-2){1'b0}}, off};
  assign unused_hi = eff[30:24];

  always_comb begin
    tgt.bus  = eff[23:16];
    tgt.dev  = eff[15:11];
    tgt.fn   = eff[10:8];
    tgt.roff = eff[7:0];
  end

  always_comb begin
    lim_eff = limit_req;
    if ((limit_req > SPACE_L) && !ext_ok) lim_eff = SPACE_L;
  end

  assign roff_l   = {{(LIM_W-OFFW){1'b0}}, eff[OFFW-1:0]};
  assign in_range = roff_l < lim_eff;
  assign room     = lim_eff - roff_l;

  always_comb begin
    if (room < {{(LIM_W-3){1'b0}}, size}) len = room[2:0];
    else                                 len = size;
  end

  assign live = present && powered && !(hotplug && !fn0);
  assign pass = addr_q[DW-1] && size_legal(size) && in_range && live;

endmodule

// File: rtl/cfg_rsp.sv
`timescale 1ns/1ps
module cfg_rsp #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          sel_addr,
  input  logic          fwd_read,
  input  logic [DW-1:0] addr_q,
  input  logic [DW-1:0] dn_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [DW-1:0] rdata_d;
  logic          cap_en;

  assign cap_en = req_valid;

  always_comb begin
    if (sel_addr)      rdata_d = addr_q;
    else if (fwd_read) rdata_d = dn_rdata;
    else               rdata_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '1;
    else if (cap_en) rsp_rdata <= rdata_d;
  end

endmodule

// File: rtl/cfg_bridge.sv
`timescale 1ns/1ps
module cfg_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LIM_W = 13,
  parameter int unsigned SPACE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_win,
  input  logic             req_write,
  input  logic [1:0]       req_off,
  input  logic [2:0]       req_size,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LIM_W-1:0] win_limit,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             dn_valid,
  output logic             dn_write,
  output logic [7:0]       dn_bus,
  output logic [4:0]       dn_dev,
  output logic [2:0]       dn_fn,
  output logic [7:0]       dn_reg,
  output logic [2:0]       dn_len,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_present,
  input  logic             dn_powered,
  input  logic             dn_fn0,
  input  logic             dn_hotplug,
  input  logic             dn_ext_ok,
  input  logic [DW-1:0]    dn_rdata
);

  logic [DW-1:0] cfg_addr_q;
  logic          addr_wr;
  logic          sel_addr;
  logic          is_data;
  logic          gate_pass;
  cfg_tgt_t      tgt;

  assign sel_addr = req_valid && (win_e'(req_win) == WIN_ADDR);
  assign is_data  = req_valid && (win_e'(req_win) == WIN_DATA);
  assign addr_wr  = sel_addr && req_write && (req_off == 2'd0) && (req_size == 3'd4);

  cfg_addr_reg #(.DW(DW)) u_areg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (addr_wr),
    .wdata  (req_wdata),
    .addr_q (cfg_addr_q)
  );

  cfg_gate #(.DW(DW), .LIM_W(LIM_W), .SPACE(SPACE)) u_gate (
    .addr_q    (cfg_addr_q),
    .off       (req_off),
    .size      (req_size),
    .limit_req (win_limit),
    .present   (dn_present),
    .powered   (dn_powered),
    .fn0       (dn_fn0),
    .hotplug   (dn_hotplug),
    .ext_ok    (dn_ext_ok),
    .tgt       (tgt),
    .len       (dn_len),
    .pass      (gate_pass)
  );

  assign dn_valid = is_data && gate_pass;
  assign dn_write = req_write;
  assign dn_bus   = tgt.bus;
  assign dn_dev   = tgt.dev;
  assign dn_fn    = tgt.fn;
  assign dn_reg   = tgt.roff;
  assign dn_wdata = req_wdata;

  cfg_rsp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .sel_addr  (sel_addr),
    .fwd_read  (dn_valid && !req_write),
    .addr_q    (cfg_addr_q),
    .dn_rdata  (dn_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/cfg_bridge_chk.sv
`timescale 1ns/1ps
module cfg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_win,
  input logic        req_write,
  input logic [1:0]  req_off,
  input logic [2:0]  req_size,
  input logic        dn_valid,
  input logic [2:0]  dn_len,
  input logic        dn_present,
  input logic        dn_powered,
  input logic        dn_fn0,
  input logic        dn_hotplug,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [31:0] cfg_addr_q
);

  AST_ADDR_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_win && req_write && !(req_off == 2'd0 && req_size == 3'd4)) |=> $stable(cfg_addr_q)); // R2
  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> cfg_addr_q[31]); // R4
  AST_DISABLED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win && !req_write && !cfg_addr_q[31]) |=> (rsp_rdata == 32'hFFFF_FFFF)); // R4
  AST_LIVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_present && dn_powered)); // R6
  AST_NO_ORPHAN: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !(dn_hotplug && !dn_fn0)); // R9
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_len != 3'd0 && dn_len <= req_size)); // R8
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4)); // R10
  AST_DN_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (req_valid && req_win)); // R11
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R11

endmodule

bind cfg_bridge cfg_bridge_chk u_chk (.*);

// File: tb/cfg_bridge_bench.sv
`timescale 1ns/1ps
module cfg_bridge_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_win, req_write;
  logic [1:0]  req_off;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic [12:0] win_limit;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        dn_valid, dn_write;
  logic [7:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [7:0]  dn_reg;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  logic        dn_present, dn_powered, dn_fn0, dn_hotplug, dn_ext_ok;
  logic [31:0] dn_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_addr;
  logic [31:0] exp_q[$];
  bit          rd_q[$];
  string       tag_q[$];

  cfg_bridge u_cfg_bridge (.*);

  // simple target: read data encodes the address it was asked for
  assign dn_rdata = {dn_bus, dn_dev, dn_fn, dn_reg, 8'hC3};

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit win, input bit wr, input logic [1:0] off,
                        input logic [2:0] sz, input logic [31:0] wd, input string rq);
    logic [31:0] eff;
    logic [12:0] lim, room;
    logic [2:0]  elen;
    bit          pass;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_write = wr;
    req_off = off; req_size = sz; req_wdata = wd;
    #1;
    exp = 32'hFFFF_FFFF;
    if (!win) begin
      chk(dn_valid == 1'b0, rq, "dn_valid on addr window", {31'b0, dn_valid}, 32'h0);
      exp = m_addr;
      if (wr && off == 2'd0 && sz == 3'd4) m_addr = wd;
    end else begin
      eff  = m_addr | {30'b0, off};
      lim  = (win_limit > 13'd256 && !dn_ext_ok) ? 13'd256 : win_limit;
      room = lim - {5'b0, eff[7:0]};
      elen = (room < {10'b0, sz}) ? room[2:0] : sz;
      pass = m_addr[31] && (sz == 3'd1 || sz == 3'd2 || sz == 3'd4) &&
             ({5'b0, eff[7:0]} < lim) && dn_present && dn_powered &&
             !(dn_hotplug && !dn_fn0);
      chk(dn_valid == pass, rq, "dn_valid", {31'b0, dn_valid}, {31'b0, pass});
      if (pass) begin
        chk({dn_bus, dn_dev, dn_fn, dn_reg} == eff[23:0], rq, "decode",
            {8'b0, dn_bus, dn_dev, dn_fn, dn_reg}, {8'b0, eff[23:0]});
        chk(dn_len == elen, rq, "dn_len", {29'b0, dn_len}, {29'b0, elen});
        chk(dn_write == wr, rq, "dn_write", {31'b0, dn_write}, {31'b0, wr});
        if (wr) chk(dn_wdata == wd, "R12", "dn_wdata", dn_wdata, wd);
        else    exp = {eff[23:0], 8'hC3};
      end
    end
    exp_q.push_back(exp);
    rd_q.push_back(!wr);
    tag_q.push_back(rq);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected rsp_valid", 32'h1, 32'h0);
        end else begin
          logic [31:0] e;
          bit          r;
          string       t;
          e = exp_q.pop_front();
          r = rd_q.pop_front();
          t = tag_q.pop_front();
          if (r) chk(rsp_rdata == e, t, "rsp_rdata", rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_win = 1'b0; req_write = 1'b0;
    req_off = 2'd0; req_size = 3'd4; req_wdata = '0; win_limit = 13'd256;
    dn_present = 1'b1; dn_powered = 1'b1; dn_fn0 = 1'b1; dn_hotplug = 1'b0;
    dn_ext_ok = 1'b0; m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk(dn_valid == 1'b0, "R1", "dn_valid after reset", {31'b0, dn_valid}, 32'h0);

    // R1: reset state
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, "R1");
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R1");

    // R2: partial address writes dropped, R3: full readback
    access(1'b0, 1'b1, 2'd1, 3'd4, 32'h8000_1234, "R2");
    access(1'b0, 1'b1, 2'd0, 3'd2, 32'h8000_5678, "R2");
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, "R2");
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8003_5A10, "R2");
    access(1'b0, 1'b0, 2'd3, 3'd1, '0, "R3");
    access(1'b0, 1'b0, 2'd2, 3'd2, '0, "R3");

    // R5/R11: decode and read return; R12 write forward
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R5");
    access(1'b1, 1'b0, 2'd2, 3'd2, '0, "R5");
    access(1'b1, 1'b0, 2'd3, 3'd1, '0, "R11");
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'hDEAD_BEEF, "R12");
    access(1'b1, 1'b1, 2'd1, 3'd1, 32'h0000_00A5, "R12");

    // R10: illegal sizes
    access(1'b1, 1'b0, 2'd0, 3'd3, '0, "R10");
    access(1'b1, 1'b1, 2'd0, 3'd0, 32'h1, "R10");

    // R6: absent target
    idle(); dn_present = 1'b0;
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R6");
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h5, "R6");
    idle(); dn_present = 1'b1; dn_powered = 1'b0;
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R9");
    idle(); dn_powered = 1'b1; dn_hotplug = 1'b1; dn_fn0 = 1'b0;
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R9");
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h7, "R9");
    idle(); dn_fn0 = 1'b1;
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R9");
    idle(); dn_hotplug = 1'b0;

    // R7/R8: limits and truncation
    idle(); win_limit = 13'h040;
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8003_5A3C, "R7");
    access(1'b1, 1'b0, 2'd2, 3'd4, '0, "R8");
    access(1'b1, 1'b0, 2'd3, 3'd2, '0, "R8");
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8003_5A40, "R7");
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R7");
    access(1'b1, 1'b1, 2'd0, 3'd1, 32'h9, "R7");
    idle(); win_limit = 13'h200;
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8003_5AFC, "R7");
    access(1'b1, 1'b0, 2'd2, 3'd4, '0, "R7");
    idle(); dn_ext_ok = 1'b1;
    access(1'b1, 1'b0, 2'd2, 3'd4, '0, "R8");
    access(1'b1, 1'b0, 2'd3, 3'd4, '0, "R8");

    // R4: enable cleared
    idle(); dn_ext_ok = 1'b0; win_limit = 13'd256;
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h0003_5A10, "R4");
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, "R4");
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h3, "R4");
    access(1'b0, 1'b0, 2'd1, 3'd4, '0, "R3");
    idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule